// File: doc/BRIEF.md
# Excess-One Carry Select Adder Slice

This block is an 8-bit adder slice meant for the upper section of a wide carry select adder. It first forms the plain sum of its two operands with an assumed carry-in of zero. The sum for a carry-in of one is not produced by a second ripple adder. Instead, the plain sum is incremented by excess-one converters, which are cheap chains of AND and XOR gates.

The increment path is split into two 4-bit segments. Each segment has its own converter and its own 4-bit selector. The lower segment is selected by the incoming carry. The upper segment is selected by that carry ANDed with the lower converter's all-ones term. The upper increment decision therefore never waits on a full 8-bit AND chain.

The selection is written as an ordinary multiplexer so that it synthesizes on any fabric. Both the sum and the carry-out are registered, which gives the slice a latency of one clock.

Top module: `bec_csel_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` and `cout_q` become zero on that edge, whatever the operand inputs are.
- R2: Results appear one clock after the operands. Inputs applied between edges do not change `sum_q` or `cout_q` before the next rising edge, and do change them at that edge.
- R3: With `cin` = 0, `sum_q` equals (`a_in` + `b_in`) mod 256 and `cout_q` equals bit 8 of that unsigned sum.
- R4: With `cin` = 1, `sum_q` equals (`a_in` + `b_in` + 1) mod 256.
- R5: With `cin` = 1, bits 3:0 of `sum_q` equal the plain lower nibble sum plus one, mod 16, where the plain sum is formed with no carry-in.
- R6: With `cin` = 1, bits 7:4 of `sum_q` are the plain upper nibble incremented by one only when bits 3:0 of the plain sum are all ones (4'hF). Otherwise they equal the plain upper nibble.
- R7: `cout_q` equals the plain carry-out OR (`cin` AND all eight plain sum bits equal to one).
- R8: When `a_in` + `b_in` = 8'hFF and `cin` = 1, the carry propagates through both segments: `sum_q` = 8'h00 and `cout_q` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | First addend slice |
| b_in | input | 8 | Second addend slice |
| cin | input | 1 | Carry into the slice |
| sum_q | output | 8 | Registered sum |
| cout_q | output | 1 | Registered carry out of the slice |

## Verification
The bench targets the nibble boundary, where a plain lower sum of 4'hF must lift the upper nibble when `cin` is set. A design that fed the upper selector from `cin` alone would produce results that are 16 too large or too small. The all-ones plain sum with `cin` set is also checked: a broken chain between the two converters would leave 8'hF0 or 8'hFF on the output, and a missing OR term would drop the carry-out. Every operand pair is also run with both carry values, so an inverted selector or a swapped converter bit appears as a wrong sum.

// File: rtl/bcsa_pkg.sv
package bcsa_pkg;
  // Default geometry of the slice: segments of SEG_W bits, NUM_SEG of them.
  localparam int unsigned SEG_W_DEF   = 4;
  localparam int unsigned NUM_SEG_DEF = 2;

  // Width of a full slice for a given geometry.
  function automatic int unsigned slice_width(input int unsigned seg_w, input int unsigned nseg);
    return seg_w * nseg;
  endfunction
endpackage

// File: rtl/bcsa_ripple.sv
// Plain ripple adder with carry-in fixed at zero.
module bcsa_ripple #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign cout = carry[W];
endmodule

// File: rtl/bcsa_excess1.sv
// N-bit binary to excess-one converter. It also exposes the end of its AND chain.
module bcsa_excess1 #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] v,
  output logic [N-1:0] inc,
  output logic         all_ones
);
  logic [N-1:0] chain;

  assign chain[0] = 1'b1;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign chain[i] = chain[i-1] & v[i-1];
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign inc[i] = v[i] ^ chain[i];
  end

  assign all_ones = chain[N-1] & v[N-1];
endmodule

// File: rtl/bcsa_segment.sv
// One segment: converter plus selector. It forwards the select to the next segment.
module bcsa_segment #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] plain,
  input  logic         sel,
  output logic [N-1:0] result,
  output logic         sel_next
);
  logic [N-1:0] bumped;
  logic         full;

  bcsa_excess1 #(.N(N)) u_conv (
    .v        (plain),
    .inc      (bumped),
    .all_ones (full)
  );

  always_comb begin
    if (sel) result = bumped;
    else     result = plain;
  end

  assign sel_next = sel & full;
endmodule

// File: rtl/bec_csel_adder.sv
module bec_csel_adder #(
  parameter int unsigned SEG_W   = bcsa_pkg::SEG_W_DEF,
  parameter int unsigned NUM_SEG = bcsa_pkg::NUM_SEG_DEF,
  localparam int unsigned W      = bcsa_pkg::slice_width(SEG_W, NUM_SEG)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic [W-1:0] sum_q,
  output logic         cout_q
);
  logic [W-1:0]     plain_sum;
  logic             plain_cout;
  logic [W-1:0]     sel_sum;
  logic [NUM_SEG:0] seg_sel;

  bcsa_ripple #(.W(W)) u_rca (
    .a    (a_in),
    .b    (b_in),
    .sum  (plain_sum),
    .cout (plain_cout)
  );

  assign seg_sel[0] = cin;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    bcsa_segment #(.N(SEG_W)) u_seg (
      .plain    (plain_sum[s*SEG_W +: SEG_W]),
      .sel      (seg_sel[s]),
      .result   (sel_sum[s*SEG_W +: SEG_W]),
      .sel_next (seg_sel[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sel_sum;
      cout_q <= plain_cout | seg_sel[NUM_SEG];
    end
  end
endmodule

// File: rtl/bec_csel_adder_chk.sv
module bec_csel_adder_chk #(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned W     = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         cin,
  input logic [W-1:0] sum_q,
  input logic         cout_q
);
  logic [W:0] ref_plain;
  logic [W:0] ref_inc;

  assign ref_plain = {1'b0, a_in} + {1'b0, b_in};
  assign ref_inc   = ref_plain + {{W{1'b0}}, 1'b1};

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sum_q == '0 && !cout_q)); // R1

  AST_SUM_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    !cin |=> ({cout_q, sum_q} == $past(ref_plain))); // R3

  AST_SUM_WITH_CARRY: assert property (@(posedge clk) disable iff (rst)
    cin |=> (sum_q == $past(ref_inc[W-1:0]))); // R4

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (cin && ref_plain[SEG_W-1:0] != {SEG_W{1'b1}}) |=> (sum_q[W-1:SEG_W] == $past(ref_plain[W-1:SEG_W]))); // R6

  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cout_q == $past(ref_plain[W] | (cin & (&ref_plain[W-1:0]))))); // R7

  AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (cin && (&ref_plain[W-1:0])) |=> (sum_q == '0 && cout_q)); // R8
endmodule

bind bec_csel_adder bec_csel_adder_chk #(.SEG_W(SEG_W), .W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_in   (a_in),
  .b_in   (b_in),
  .cin    (cin),
  .sum_q  (sum_q),
  .cout_q (cout_q)
);

// File: tb/bec_csel_adder_test.sv
`timescale 1ns/1ps
module bec_csel_adder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0;
  logic [7:0] b_in = '0;
  logic       cin = 1'b0;
  logic [7:0] sum_q;
  logic       cout_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bec_csel_adder uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  // Each entry: {a, b, cin, expected cout, expected sum}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
    {8'h00, 8'h00, 1'b1, 1'b0, 8'h01},
    {8'h0F, 8'h00, 1'b1, 1'b0, 8'h10},
    {8'h0F, 8'h00, 1'b0, 1'b0, 8'h0F},
    {8'hFF, 8'h00, 1'b1, 1'b1, 8'h00},
    {8'h80, 8'h7F, 1'b1, 1'b1, 8'h00},
    {8'hFF, 8'hFF, 1'b0, 1'b1, 8'hFE},
    {8'hFF, 8'hFF, 1'b1, 1'b1, 8'hFF},
    {8'h12, 8'h34, 1'b0, 1'b0, 8'h46},
    {8'h12, 8'h34, 1'b1, 1'b0, 8'h47},
    {8'h0E, 8'h01, 1'b1, 1'b0, 8'h10},
    {8'h3C, 8'hC3, 1'b1, 1'b1, 8'h00},
    {8'hF0, 8'h0F, 1'b0, 1'b0, 8'hFF},
    {8'hA5, 8'h5A, 1'b1, 1'b1, 8'h00},
    {8'h17, 8'h08, 1'b1, 1'b0, 8'h20},
    {8'h1F, 8'hE0, 1'b1, 1'b1, 8'h00},
    {8'h7F, 8'h7F, 1'b1, 1'b0, 8'hFF},
    {8'h8F, 8'h00, 1'b1, 1'b0, 8'h90}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c);
    @(negedge clk);
    a_in = a; b_in = b; cin = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state (R1)
    a_in = 8'hFF; b_in = 8'hFF; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sum after reset", 32'(sum_q), 32'h0);
    chk("R1 cout after reset", 32'(cout_q), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk (R3 for cin 0, R4 for cin 1, carry-out R7)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
      chk(VEC[i][9] ? "R4 table sum" : "R3 table sum", 32'(sum_q), 32'(VEC[i][7:0]));
      chk("R7 table cout", 32'(cout_q), 32'(VEC[i][8]));
    end

    // Latency (R2): new inputs must not show before the edge
    apply(8'h01, 8'h02, 1'b0);
    @(negedge clk);
    a_in = 8'h40; b_in = 8'h05; cin = 1'b1;
    #1;
    chk("R2 held before edge", 32'(sum_q), 32'h03);
    @(posedge clk);
    #1;
    chk("R2 updated at edge", 32'(sum_q), 32'h46);

    // Synchronous reset mid-run with active operands (R1)
    @(negedge clk);
    a_in = 8'hFF; b_in = 8'h01; cin = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 sum mid-run reset", 32'(sum_q), 32'h0);
    chk("R1 cout mid-run reset", 32'(cout_q), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Exhaustive sweep against a reference sum
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          int exp;
          apply(8'(ai), 8'(bi), 1'(ci));
          exp = ai + bi + ci;
          if (ci == 1) begin
            chk("R5 lower nibble", 32'(sum_q[3:0]), 32'(((ai + bi) + 1) & 15));
            chk("R6 upper nibble", 32'(sum_q[7:4]), 32'((exp >> 4) & 15));
          end else begin
            chk("R3 sum", 32'(sum_q), 32'(exp & 255));
          end
          chk("R7 cout", 32'(cout_q), 32'((exp >> 8) & 1));
          if (ci == 1 && ((ai + bi) & 255) == 255) begin
            chk("R8 full propagation sum", 32'(sum_q), 32'h0);
            chk("R8 full propagation cout", 32'(cout_q), 32'h1);
          end
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule